// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits at the head of an Ethernet receive path that moves 16-bit words. It holds the first three words of every incoming frame, compares them with a three-word station address, and then does one of three things. It passes the frame on, it passes the frame on without regard to the address, or it drops the frame. Comparison is cumulative: each header word is XORed with its stored counterpart, and the result is ORed into a running difference register. That register starts from zero at every frame. A broadcast-style test on the first word alone can force acceptance.

An accepted frame is sent downstream on a valid/ready stream: the three held header words come out first, then the payload flows straight through until the end-of-packet word. A frame is dropped if its address does not match, if it ends inside the header, or if no receive descriptor is available. For every drop the block pulses a re-arm request so the receiver waits for the next beginning of packet. A frame that ends inside the header with the overrun status set also requests overrun recovery. A frame that matched but found no descriptor also bumps a 16-bit missed-frame counter.

Back-pressure rules: `in_ready` is always high while header words are being collected and while a dropped frame is being drained. It is low while the three held header words are replayed. During payload pass-through it equals `out_ready`. `out_valid`, once high, stays high with stable `out_data` until `out_ready` is seen.

Top module: `rxf_dst_filter`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0, every event pulse is 0 and `missed_count` is 0.
- R2: The k-th received word of a frame (k = 0, 1, 2) is compared with `sta_addr[16k+15:16k]`. The address matches only if all three words are equal, with differences accumulated as an OR of per-word XORs.
- R3: If bit 15 of (first received word OR `sta_addr[15:0]`) is 1, the frame is treated as matching whatever its second and third words are.
- R4: The decision is made on the third accepted input beat. One cycle later exactly one of `frame_accept` or `frame_discard` pulses for one cycle. On a mismatch `frame_discard` and `rx_rearm` pulse, and the rest of the frame is consumed with `in_ready` high and produces no output.
- R5: A frame whose `in_last` beat is one of its first three beats is dropped: `frame_discard` and `rx_rearm` pulse one cycle after that beat. `ovr_recover` pulses along with them if `in_ovr` was 1 on that beat.
- R6: A matching frame with `desc_avail` low on its third beat is dropped. `frame_discard`, `rx_rearm` and `miss_inc` pulse together, and `missed_count` increases by one (16-bit, wrapping) in the same cycle.
- R7: For an accepted frame, `out_data` carries the three header words in received order with `out_last` 0. It then carries the remaining words unchanged, with `out_last` 1 on the word that arrived with `in_last`.
- R8: `in_ready` is 0 during header replay and equals `out_ready` during pass-through. While `out_valid` is high and `out_ready` low during replay, `out_data` holds its value.
- R9: The difference register and the accept-all flag restart at each new frame, so a mismatching frame has no effect on the decision for the frame that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sta_addr | input | 48 | Station address, word k at bits 16k+15:16k |
| desc_avail | input | 1 | A receive descriptor is queued |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word taken when high with in_valid |
| in_data | input | 16 | Input word |
| in_last | input | 1 | Input word is the last of its frame |
| in_ovr | input | 1 | Receive-overrun status, meaningful with in_last |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts output word |
| out_data | output | 16 | Output word |
| out_last | output | 1 | Output word is the last of the frame |
| frame_accept | output | 1 | One-cycle pulse: frame accepted |
| frame_discard | output | 1 | One-cycle pulse: frame dropped |
| rx_rearm | output | 1 | One-cycle pulse: receiver should wait for next beginning of packet |
| ovr_recover | output | 1 | One-cycle pulse: run overrun recovery |
| miss_inc | output | 1 | One-cycle pulse: missed-frame count incremented |
| missed_count | output | 16 | Missed-frame counter |

## Verification
Decision pulses and the missed counter change on the edge after the third header beat, or after the `in_last` beat of a short frame. Header replay begins in that same cycle. Pass-through words appear at the output combinationally, in the cycle they are offered. The bench keeps a behavioural model that advances on every rising edge from the same inputs. Every output, including `in_ready`, is compared with the model shortly before the next rising edge, so each result is checked in exactly the cycle it is due. Directed checks after each frame confirm the total of accepts, drops and missed frames.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_EMIT = 2'd1,
    ST_PASS = 2'd2,
    ST_SKIP = 2'd3
  } rxf_state_e;
endpackage

// File: rtl/rxf_addr_cmp.sv
module rxf_addr_cmp #(
  parameter int W  = 16,
  parameter int N  = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           beat,
  input  logic [IW-1:0]  idx,
  input  logic [W-1:0]   word,
  input  logic [N*W-1:0] addr,
  output logic           pass_now
);
  logic [W-1:0] aw [N];
  logic [W-1:0] diff_q, base, diff_now;
  logic         all_q;

  for (genvar g = 0; g < N; g++) begin : g_aw
    assign aw[g] = addr[g*W +: W];
  end

  // first word of each frame starts from a clean difference
  assign base     = (idx == '0) ? '0 : diff_q;
  assign diff_now = base | (word ^ aw[idx]);
  assign pass_now = all_q | (diff_now == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      diff_q <= '0;
      all_q  <= 1'b0;
    end else if (beat) begin
      diff_q <= diff_now;
      if (idx == '0) all_q <= word[W-1] | aw[0][W-1];
    end
  end

  // R2 / R9: an equal first word leaves a clean difference regardless of history
  p_first_word_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && idx == '0 && word == aw[0]) |=> (diff_q == '0));

  // R3: a set top bit on the first word raises the accept-all flag
  p_accept_all_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && idx == '0 && word[W-1]) |=> all_q);
endmodule

// File: rtl/rxf_hdr_buf.sv
module rxf_hdr_buf #(
  parameter int W  = 16,
  parameter int N  = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          wr,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ridx,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr && widx == IW'(g)) mem[g] <= wdata;
    end
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/rxf_dst_filter.sv
module rxf_dst_filter
  import rxf_pkg::*;
#(
  parameter int W     = 16,
  parameter int N     = 3,
  parameter int CNT_W = 16,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N*W-1:0]   sta_addr,
  input  logic             desc_avail,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_data,
  input  logic             in_last,
  input  logic             in_ovr,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_data,
  output logic             out_last,
  output logic             frame_accept,
  output logic             frame_discard,
  output logic             rx_rearm,
  output logic             ovr_recover,
  output logic             miss_inc,
  output logic [CNT_W-1:0] missed_count
);
  localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);

  rxf_state_e    st_q;
  logic [IW-1:0] idx_q;
  logic          beat, hdr_beat, pass_now;
  logic [W-1:0]  buf_data;

  always_comb begin
    unique case (st_q)
      ST_HDR, ST_SKIP: in_ready = 1'b1;
      ST_PASS:         in_ready = out_ready;
      default:         in_ready = 1'b0;
    endcase
  end

  assign beat      = in_valid & in_ready;
  assign hdr_beat  = beat & (st_q == ST_HDR);
  assign out_valid = (st_q == ST_EMIT) | ((st_q == ST_PASS) & in_valid);
  assign out_data  = (st_q == ST_EMIT) ? buf_data : in_data;
  assign out_last  = (st_q == ST_PASS) & in_last;

  rxf_addr_cmp #(.W(W), .N(N)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat     (hdr_beat),
    .idx      (idx_q),
    .word     (in_data),
    .addr     (sta_addr),
    .pass_now (pass_now)
  );

  rxf_hdr_buf #(.W(W), .N(N)) u_buf (
    .clk   (clk),
    .wr    (hdr_beat),
    .widx  (idx_q),
    .wdata (in_data),
    .ridx  (idx_q),
    .rdata (buf_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= ST_HDR;
      idx_q         <= '0;
      frame_accept  <= 1'b0;
      frame_discard <= 1'b0;
      rx_rearm      <= 1'b0;
      ovr_recover   <= 1'b0;
      miss_inc      <= 1'b0;
      missed_count  <= '0;
    end else begin
      frame_accept  <= 1'b0;
      frame_discard <= 1'b0;
      rx_rearm      <= 1'b0;
      ovr_recover   <= 1'b0;
      miss_inc      <= 1'b0;
      unique case (st_q)
        ST_HDR: begin
          if (hdr_beat) begin
            if (in_last) begin
              frame_discard <= 1'b1;
              rx_rearm      <= 1'b1;
              ovr_recover   <= in_ovr;
              idx_q         <= '0;
            end else if (idx_q == LAST_IDX) begin
              idx_q <= '0;
              if (pass_now && desc_avail) begin
                frame_accept <= 1'b1;
                st_q         <= ST_EMIT;
              end else begin
                frame_discard <= 1'b1;
                rx_rearm      <= 1'b1;
                st_q          <= ST_SKIP;
                if (pass_now) begin
                  miss_inc     <= 1'b1;
                  missed_count <= missed_count + CNT_W'(1);
                end
              end
            end else begin
              idx_q <= idx_q + IW'(1);
            end
          end
        end
        ST_EMIT: begin
          if (out_ready) begin
            if (idx_q == LAST_IDX) begin
              idx_q <= '0;
              st_q  <= ST_PASS;
            end else begin
              idx_q <= idx_q + IW'(1);
            end
          end
        end
        default: begin
          if (beat && in_last) st_q <= ST_HDR;
        end
      endcase
    end
  end

  // R4: never accept and drop together
  p_one_decision_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_accept, frame_discard}));

  // R6: a missed frame is also a drop with re-arm, and the count steps by one
  p_miss_is_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    miss_inc |-> (frame_discard && rx_rearm));
  p_miss_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    miss_inc |-> (missed_count == $past(missed_count) + CNT_W'(1)));

  // R6: acceptance needs a descriptor at decision time
  p_accept_needs_desc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_accept |-> $past(desc_avail));

  // R5: overrun recovery only accompanies a drop
  p_ovr_with_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_recover |-> (frame_discard && rx_rearm));

  // R8: a stalled replay word is held
  p_replay_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EMIT && !out_ready) |=> $stable(out_data));
endmodule

// File: tb/rxf_dst_filter_tb.sv
`timescale 1ns/100ps
module rxf_dst_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [47:0] sta_addr;
  logic        desc_avail;
  logic        in_valid, in_ready, in_last, in_ovr;
  logic [15:0] in_data;
  logic        out_valid, out_ready, out_last;
  logic [15:0] out_data;
  logic        frame_accept, frame_discard, rx_rearm, ovr_recover, miss_inc;
  logic [15:0] missed_count;

  always #2.5 clk = ~clk;

  rxf_dst_filter u_dut (
    .clk(clk), .rst_n(rst_n), .sta_addr(sta_addr), .desc_avail(desc_avail),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_ovr(in_ovr), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .frame_accept(frame_accept), .frame_discard(frame_discard),
    .rx_rearm(rx_rearm), .ovr_recover(ovr_recover), .miss_inc(miss_inc),
    .missed_count(missed_count)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit bp_mode = 0;
  int acc_seen = 0, dis_seen = 0, ovr_seen = 0, out_words = 0;
  logic [15:0] fw [16];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // behavioural reference: 0 collect, 1 replay, 2 pass, 3 drain
  int          m_st = 0, m_cnt = 0;
  logic [15:0] m_hw [3];
  logic [15:0] m_diff = '0;
  bit          m_all = 0;
  bit          e_acc = 0, e_dis = 0, e_rearm = 0, e_ovr = 0, e_miss = 0;
  logic [15:0] e_missed = '0;

  function automatic logic [15:0] addr_word(input int k);
    return sta_addr[k*16 +: 16];
  endfunction

  function automatic bit m_ready();
    if (m_st == 1) return 1'b0;
    if (m_st == 2) return out_ready;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    bit hs;
    logic [15:0] d;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_diff = '0; m_all = 0;
      e_acc = 0; e_dis = 0; e_rearm = 0; e_ovr = 0; e_miss = 0; e_missed = '0;
    end else begin
      hs = in_valid && m_ready();
      e_acc = 0; e_dis = 0; e_rearm = 0; e_ovr = 0; e_miss = 0;
      if (m_st == 0) begin
        if (hs) begin
          m_hw[m_cnt] = in_data;
          d = ((m_cnt == 0) ? 16'h0 : m_diff) | (in_data ^ addr_word(m_cnt));
          if (m_cnt == 0) m_all = in_data[15] | addr_word(0)[15];
          m_diff = d;
          if (in_last) begin
            e_dis = 1; e_rearm = 1; e_ovr = in_ovr; m_cnt = 0;
          end else if (m_cnt == 2) begin
            m_cnt = 0;
            if (m_all || d == 16'h0) begin
              if (desc_avail) begin e_acc = 1; m_st = 1; end
              else begin
                e_dis = 1; e_rearm = 1; e_miss = 1; e_missed = e_missed + 16'd1; m_st = 3;
              end
            end else begin
              e_dis = 1; e_rearm = 1; m_st = 3;
            end
          end else m_cnt++;
        end
      end else if (m_st == 1) begin
        if (out_ready) begin
          if (m_cnt == 2) begin m_cnt = 0; m_st = 2; end
          else m_cnt++;
        end
      end else begin
        if (hs && in_last) m_st = 0;
      end
    end
  end

  // compare every cycle shortly before the next rising edge
  always @(negedge clk) begin
    bit ev;
    #2;
    if (rst_n === 1'b1 && !done) begin
      ev = (m_st == 1) || (m_st == 2 && in_valid);
      chk(in_ready === m_ready(), "R8 in_ready", in_ready, m_ready());
      chk(out_valid === ev, "R7 out_valid", out_valid, ev);
      if (ev) begin
        chk(out_data === ((m_st == 1) ? m_hw[m_cnt] : in_data), "R7 out_data",
            out_data, (m_st == 1) ? m_hw[m_cnt] : in_data);
        chk(out_last === ((m_st == 2) && in_last), "R7 out_last", out_last, (m_st == 2) && in_last);
        if (out_ready) out_words++;
      end
      chk(frame_accept === e_acc, "R4 frame_accept", frame_accept, e_acc);
      chk(frame_discard === e_dis, "R4 frame_discard", frame_discard, e_dis);
      chk(rx_rearm === e_rearm, "R4 rx_rearm", rx_rearm, e_rearm);
      chk(ovr_recover === e_ovr, "R5 ovr_recover", ovr_recover, e_ovr);
      chk(miss_inc === e_miss, "R6 miss_inc", miss_inc, e_miss);
      chk(missed_count === e_missed, "R6 missed_count", missed_count, e_missed);
      if (frame_accept === 1'b1) acc_seen++;
      if (frame_discard === 1'b1) dis_seen++;
      if (ovr_recover === 1'b1) ovr_seen++;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      out_ready = bp_mode ? 1'($urandom_range(0, 1)) : 1'b1;
    end
  end

  task automatic send_frame(input int len, input bit ovr);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = fw[i];
      in_last  = (i == len - 1);
      in_ovr   = ovr && (i == len - 1);
      forever begin
        #2;
        if (in_ready) begin
          @(posedge clk);
          break;
        end
        @(negedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_ovr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fill_match(input int len);
    for (int i = 0; i < 16; i++)
      fw[i] = (i < 3) ? sta_addr[i*16 +: 16] : 16'(i * 16'h0111 + 16'h0005);
    if (len < 0) fw[0] = 16'h0;
  endtask

  initial begin
    int a0, d0, w0, o0;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_last = 1'b0; in_ovr = 1'b0;
    out_ready = 1'b1; desc_avail = 1'b1;
    sta_addr = {16'h3c5a, 16'h1234, 16'h0a0b};
    repeat (3) @(negedge clk);
    #2;
    // R1 reset state
    chk(in_ready === 1'b1, "R1 in_ready after reset", in_ready, 1);
    chk(out_valid === 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(missed_count === 16'h0, "R1 missed_count after reset", missed_count, 0);
    chk({frame_accept, frame_discard, rx_rearm, ovr_recover, miss_inc} === 5'b0,
        "R1 pulses after reset", {frame_accept, frame_discard, rx_rearm, ovr_recover, miss_inc}, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    // R2 exact match, R7 words out
    fill_match(6);
    a0 = acc_seen; w0 = out_words;
    send_frame(6, 0); idle(6);
    chk(acc_seen == a0 + 1, "R2 matching frame accepted", acc_seen, a0 + 1);
    chk(out_words == w0 + 6, "R7 all words forwarded", out_words, w0 + 6);

    // R4 mismatch in the second word
    fill_match(5); fw[1] = 16'h1235;
    d0 = dis_seen; w0 = out_words;
    send_frame(5, 0); idle(6);
    chk(dis_seen == d0 + 1, "R4 mismatch dropped", dis_seen, d0 + 1);
    chk(out_words == w0, "R4 dropped frame gives no output", out_words, w0);

    // R9 matching frame right after the mismatch
    fill_match(4);
    a0 = acc_seen;
    send_frame(4, 0); idle(6);
    chk(acc_seen == a0 + 1, "R9 match after mismatch accepted", acc_seen, a0 + 1);

    // R3 accept-all from the received first word
    fill_match(5); fw[0] = 16'h8001; fw[1] = 16'hffff; fw[2] = 16'h0000;
    a0 = acc_seen;
    send_frame(5, 0); idle(6);
    chk(acc_seen == a0 + 1, "R3 top bit on first word accepts", acc_seen, a0 + 1);

    // R9 accept-all flag does not leak into the next frame
    fill_match(4); fw[2] = 16'h0000;
    d0 = dis_seen;
    send_frame(4, 0); idle(6);
    chk(dis_seen == d0 + 1, "R9 accept-all cleared next frame", dis_seen, d0 + 1);

    // R6 no descriptor
    desc_avail = 1'b0;
    fill_match(5);
    d0 = dis_seen;
    send_frame(5, 0); idle(6);
    chk(dis_seen == d0 + 1, "R6 no descriptor dropped", dis_seen, d0 + 1);
    chk(missed_count === 16'd1, "R6 missed count one", missed_count, 1);
    // mismatch without descriptor is not a missed frame
    fill_match(5); fw[2] = 16'h7777;
    send_frame(5, 0); idle(6);
    chk(missed_count === 16'd1, "R6 mismatch not counted missed", missed_count, 1);
    desc_avail = 1'b1;

    // R5 short frames, with and without overrun
    for (int len = 1; len <= 3; len++) begin
      fill_match(len);
      d0 = dis_seen; o0 = ovr_seen; a0 = acc_seen;
      send_frame(len, (len != 2)); idle(4);
      chk(dis_seen == d0 + 1, "R5 short frame dropped", dis_seen, d0 + 1);
      chk(acc_seen == a0, "R5 short frame not accepted", acc_seen, a0);
      chk(ovr_seen == o0 + ((len != 2) ? 1 : 0), "R5 overrun recovery", ovr_seen, o0 + ((len != 2) ? 1 : 0));
    end

    // R8 back-pressure on a long accepted frame
    bp_mode = 1;
    for (int k = 0; k < 4; k++) begin
      fill_match(12);
      a0 = acc_seen; w0 = out_words;
      send_frame(12, 0); idle(8);
      chk(acc_seen == a0 + 1, "R8 accepted under back-pressure", acc_seen, a0 + 1);
      chk(out_words == w0 + 12, "R8 words forwarded under back-pressure", out_words, w0 + 12);
    end

    // R3 address whose first word has the top bit set accepts anything
    bp_mode = 0;
    sta_addr = {16'h3c5a, 16'h1234, 16'h8a0b};
    idle(1);
    fill_match(4); fw[0] = 16'h0001; fw[1] = 16'h5555;
    a0 = acc_seen;
    send_frame(4, 0); idle(6);
    chk(acc_seen == a0 + 1, "R3 stored top bit accepts all", acc_seen, a0 + 1);

    idle(4);
    finish_sim();
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      finish_sim();
    end
  end
endmodule